// File: doc/BRIEF.md
# Scanline Span Rasteriser with Depth Test

This block draws a 3D scene one video line at a time, without a frame buffer. When a line starts, it gives the previously drawn line buffer to the display side. It then empties the other color/depth buffer pair and scans a small table of pre-computed triangle setup records. Each record describes a flat-topped or flat-bottomed screen triangle by an apex, a y range and per-line slopes for its left and right edges.

For every record whose y range holds the current line, a search stage works out the span's integer x endpoints, the depth at each end and the per-pixel depth step. It then puts the span into a short queue. A drawing stage takes spans from the queue and walks them one pixel per cycle. A pixel is written only when it is nearer than what the line buffer already holds. The search and drawing stages run at the same time.

The display side reads the finished line by pixel index, with no wait states. Video timing is supplied from outside through the line-start pulse and the line number.

Top module: `span_raster`

## Requirements
- R1: After reset every display pixel reads color 0 and `line_dropped` is 0.
- R2: On `line_start` the buffer drawn during the previous line becomes the displayed buffer. The buffer now being drawn is emptied: its pixels read as color 0 and as the greatest depth, so no content from earlier lines remains.
- R3: All records 0 to 2^AW-1 are scanned every line. A record takes part only when ymin <= line <= ymax (both ends inclusive). Record layout from bit 0 up: dir (1), ymin (8), ymax (8), x0 (16, unsigned, 8 fraction bits), z0 (16, unsigned), dxl, dxr (16 each, signed, 8 fraction bits), dzl, dzr (16 each, signed integer), color (9).
- R4: The line offset is ymax-line when dir=1 and line-ymin when dir=0. xl = (x0 + dxl*off + 128) >>> 8, and xr is formed the same way from dxr. zl = z0 + dzl*off and zr = z0 + dzr*off.
- R5: step = ((zr-zl) <<< 8) / (xr-xl), a signed division truncated toward zero, and step is 0 when xr = xl. With xs the clamped start, the accumulator starts at (zl<<<8) + step*(xs-xl) and grows by step at each pixel. The pixel depth is bits [23:8] of the accumulator.
- R6: A pixel is written only when it is still empty in this line or when its depth is strictly less than the stored depth. When depths are equal, the record with the lower index keeps the pixel.
- R7: Span ends are clamped to 0..255. A span with xr < xl, xr < 0 or xl > 255 draws nothing.
- R8: Drawing takes one pixel per cycle. A lone 256-pixel span is complete when the next `line_start` comes 262 cycles after the first.
- R9: When the next `line_start` arrives before searching and drawing have finished, the unfinished work is dropped. `line_dropped` is then 1 until the following `line_start`; otherwise it is 0.
- R10: Searching stalls while the span queue is full and loses no span. Sixteen covering records are all drawn.
- R11: `pix_color` returns the 9-bit color of pixel `pix_x` (0..255) of the displayed buffer, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that begins a new line |
| line_y | input | 8 | Number of the line to draw, sampled with `line_start` |
| rec_addr | output | 4 | Setup record index being read |
| rec_data | input | 122 | Setup record at `rec_addr`, same cycle |
| pix_x | input | 8 | Display read pixel index |
| pix_color | output | 9 | Color of the displayed pixel |
| line_dropped | output | 1 | Displayed line was cut short |

## Verification
The bench uses the default parameters: 8-bit x, 8 fraction bits, 16-bit depth, sixteen records and a four-entry queue. With only four queue entries, sixteen covering records fill the queue and the search stage must stall, so the stall path is reached. The 256-pixel line lets a single span cross both clamp edges. It also makes the exact length of the line budget visible, so the bench can place one `line_start` just past the end of the drawing and one well before it.

// File: rtl/span_raster.sv
module span_raster #(
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int CW  = 9,
  parameter int ZW  = 16,
  parameter int FW  = 8,
  parameter int AW  = 4,
  parameter int QAW = 2,
  localparam int XF   = XW + FW,
  localparam int RW   = 1 + 2*YW + 3*XF + 3*ZW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [YW-1:0] line_y,
  output logic [AW-1:0] rec_addr,
  input  logic [RW-1:0] rec_data,
  input  logic [XW-1:0] pix_x,
  output logic [CW-1:0] pix_color,
  output logic          line_dropped
);
  localparam int NPX  = 1 << XW;
  localparam int NREC = 1 << AW;
  localparam int QD   = 1 << QAW;
  localparam int O_YL = 1;
  localparam int O_YH = O_YL + YW;
  localparam int O_X0 = O_YH + YW;
  localparam int O_Z0 = O_X0 + XF;
  localparam int O_DXL = O_Z0 + ZW;
  localparam int O_DXR = O_DXL + XF;
  localparam int O_DZL = O_DXR + XF;
  localparam int O_DZR = O_DZL + ZW;
  localparam int O_COL = O_DZR + ZW;
  localparam logic signed [31:0] HALF = 32'sd1 <<< (FW-1);
  localparam logic signed [31:0] LAST = NPX - 1;

  logic          wsel, search_on, busy;
  logic [YW-1:0] cur_y;
  logic [AW-1:0] idx;
  logic [QAW:0]  cnt;
  logic [QAW-1:0] wp, rp;
  logic [XW-1:0] px, pxe;
  logic signed [31:0] acc, stp;
  logic [CW-1:0] pcol;
  logic [NPX-1:0] vld [2];
  logic [CW-1:0] cbuf [2][NPX];
  logic [ZW-1:0] dbuf [NPX];
  logic [XW-1:0] q_xs [QD];
  logic [XW-1:0] q_xe [QD];
  logic signed [31:0] q_acc [QD];
  logic signed [31:0] q_stp [QD];
  logic [CW-1:0] q_col [QD];

  wire          r_dir = rec_data[0];
  wire [YW-1:0] r_yl  = rec_data[O_YL +: YW];
  wire [YW-1:0] r_yh  = rec_data[O_YH +: YW];
  wire [YW-1:0] off   = r_dir ? (r_yh - cur_y) : (cur_y - r_yl);
  wire covers = (cur_y >= r_yl) && (cur_y <= r_yh);

  logic signed [31:0] offs, xl, xr, zl, zr, stp_c, acc_c;
  assign offs  = $signed(32'(off));
  assign xl    = ($signed(32'(rec_data[O_X0 +: XF])) + 32'($signed(rec_data[O_DXL +: XF])) * offs + HALF) >>> FW;
  assign xr    = ($signed(32'(rec_data[O_X0 +: XF])) + 32'($signed(rec_data[O_DXR +: XF])) * offs + HALF) >>> FW;
  assign zl    = $signed(32'(rec_data[O_Z0 +: ZW])) + 32'($signed(rec_data[O_DZL +: ZW])) * offs;
  assign zr    = $signed(32'(rec_data[O_Z0 +: ZW])) + 32'($signed(rec_data[O_DZR +: ZW])) * offs;
  assign stp_c = (xr > xl) ? ((zr - zl) <<< FW) / (xr - xl) : 32'sd0;

  wire [XW-1:0] xs_c = (xl < 0) ? '0 : XW'(xl);
  wire [XW-1:0] xe_c = (xr > LAST) ? XW'(LAST) : XW'(xr);
  assign acc_c = (zl <<< FW) + stp_c * ($signed(32'(xs_c)) - xl);

  wire span_ok = covers && !(xr < xl) && !(xr < 0) && !(xl > LAST);
  wire adv  = !line_start && search_on && (cnt != (QAW+1)'(QD));
  wire push = adv && span_ok;
  wire pop  = !line_start && !busy && (cnt != 0);
  wire [ZW-1:0] dep = acc[FW +: ZW];
  wire wr = !line_start && busy && (!vld[wsel][px] || dep < dbuf[px]);

  assign rec_addr  = idx;
  assign pix_color = vld[~wsel][pix_x] ? cbuf[~wsel][pix_x] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel <= 1'b0; search_on <= 1'b0; busy <= 1'b0; cur_y <= '0; idx <= '0;
      cnt <= '0; wp <= '0; rp <= '0; px <= '0; pxe <= '0; acc <= '0; stp <= '0;
      pcol <= '0; line_dropped <= 1'b0; vld[0] <= '0; vld[1] <= '0;
    end else if (line_start) begin
      line_dropped <= search_on | busy | (cnt != 0);
      wsel <= ~wsel;
      vld[~wsel] <= '0;
      cur_y <= line_y; idx <= '0; search_on <= 1'b1;
      busy <= 1'b0; cnt <= '0; wp <= '0; rp <= '0;
    end else begin
      if (adv) begin
        idx <= idx + 1'b1;
        if (idx == AW'(NREC-1)) search_on <= 1'b0;
      end
      if (push) wp <= wp + 1'b1;
      cnt <= cnt + (QAW+1)'(push) - (QAW+1)'(pop);
      if (pop) begin
        px <= q_xs[rp]; pxe <= q_xe[rp]; acc <= q_acc[rp]; stp <= q_stp[rp];
        pcol <= q_col[rp]; rp <= rp + 1'b1; busy <= 1'b1;
      end else if (busy) begin
        if (wr) vld[wsel][px] <= 1'b1;
        if (px == pxe) busy <= 1'b0;
        else begin
          px <= px + 1'b1;
          acc <= acc + stp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_xs[wp] <= xs_c; q_xe[wp] <= xe_c; q_acc[wp] <= acc_c;
      q_stp[wp] <= stp_c; q_col[wp] <= rec_data[O_COL +: CW];
    end
    if (rst_n && wr) begin
      cbuf[wsel][px] <= pcol;
      dbuf[px] <= dep;
    end
  end

  assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> wsel != $past(wsel));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> vld[wsel] == '0);
  assert_pixel_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_start && px != pxe) |=> (busy && px == $past(px) + 1'b1));
  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (QAW+1)'(QD));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && busy) |=> line_dropped);
endmodule

// File: tb/span_raster_tb.sv
module span_raster_tb;
  logic clk = 0, rst_n = 0, line_start = 0;
  logic [7:0] line_y = 0, pix_x = 0;
  logic [3:0] rec_addr;
  logic [121:0] rec_data;
  logic [8:0] pix_color;
  logic line_dropped;
  logic [121:0] recs [16];
  int r_dir[16], r_yl[16], r_yh[16], r_x0[16], r_z0[16];
  int r_dxl[16], r_dxr[16], r_dzl[16], r_dzr[16], r_col[16];
  int ec[256], ed[256];
  bit ev[256];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign rec_data = recs[rec_addr];

  span_raster u_dut (.clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
    .rec_addr(rec_addr), .rec_data(rec_data), .pix_x(pix_x), .pix_color(pix_color),
    .line_dropped(line_dropped));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int i, input int dir, input int yl, input int yh, input int x0,
                     input int z0, input int dxl, input int dxr, input int dzl, input int dzr,
                     input int col);
    r_dir[i]=dir; r_yl[i]=yl; r_yh[i]=yh; r_x0[i]=x0; r_z0[i]=z0;
    r_dxl[i]=dxl; r_dxr[i]=dxr; r_dzl[i]=dzl; r_dzr[i]=dzr; r_col[i]=col;
    recs[i] = {9'(col), 16'(dzr), 16'(dzl), 16'(dxr), 16'(dxl), 16'(z0), 16'(x0),
               8'(yh), 8'(yl), 1'(dir)};
  endtask

  task automatic clear_recs();
    for (int i = 0; i < 16; i++) put(i, 0, 200, 199, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic void model(input int y);
    for (int p = 0; p < 256; p++) begin ev[p] = 0; ec[p] = 0; ed[p] = 0; end
    for (int i = 0; i < 16; i++) begin
      int off, xl, xr, zl, zr, stp, xs, xe, acc, d;
      if (r_yl[i] <= y && y <= r_yh[i]) begin
        off = r_dir[i] ? r_yh[i] - y : y - r_yl[i];
        xl = (r_x0[i] + r_dxl[i]*off + 128) >>> 8;
        xr = (r_x0[i] + r_dxr[i]*off + 128) >>> 8;
        zl = r_z0[i] + r_dzl[i]*off;
        zr = r_z0[i] + r_dzr[i]*off;
        if (!(xr < xl || xr < 0 || xl > 255)) begin
          stp = (xr > xl) ? ((zr - zl) <<< 8) / (xr - xl) : 0;
          xs = xl < 0 ? 0 : xl;
          xe = xr > 255 ? 255 : xr;
          acc = (zl <<< 8) + stp * (xs - xl);
          for (int p = xs; p <= xe; p++) begin
            d = (acc >>> 8) & 32'hFFFF;
            if (!ev[p] || d < ed[p]) begin ev[p] = 1; ed[p] = d; ec[p] = r_col[i]; end
            acc += stp;
          end
        end
      end
    end
  endfunction

  task automatic run_line(input int y, input int n);
    @(negedge clk); line_start = 1; line_y = 8'(y);
    @(negedge clk); line_start = 0;
    repeat (n-1) @(negedge clk);
    line_start = 1; line_y = 8'd255;
    @(negedge clk); line_start = 0;
  endtask

  task automatic check_display(input string req);
    int bad = 0, fa = 0, fe = 0, fp = -1;
    for (int p = 0; p < 256; p++) begin
      pix_x = 8'(p); #1;
      if (int'(pix_color) != ec[p]) begin
        if (fp < 0) begin fp = p; fa = pix_color; fe = ec[p]; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s pixel %0d actual=%0d expected=%0d (%0d wrong)", req, fp, fa, fe, bad);
    end
  endtask

  task automatic t_reset();
    for (int p = 0; p < 256; p++) ec[p] = 0;
    check_display("R1 reset display");
    chk("R1 reset line_dropped", line_dropped, 0);
  endtask

  task automatic t_basic();
    clear_recs();
    put(0, 0, 5, 20, 100*256+128, 1000, -2*256-64, 3*256+64, 10, -10, 9'h1A5);
    model(12); run_line(12, 300);
    check_display("R4 R11 dir0 span with rounding");
    chk("R9 no drop", line_dropped, 0);
    model(30); run_line(30, 300);
    check_display("R3 line outside y range");
    model(20); run_line(20, 300);
    check_display("R3 inclusive ymax");
  endtask

  task automatic t_dir1();
    clear_recs();
    put(3, 1, 40, 60, 128*256, 2000, -256-100, 256+100, -5, 5, 9'h0F3);
    model(50); run_line(50, 300);
    check_display("R4 dir1 offset from ymax");
  endtask

  task automatic t_interp();
    clear_recs();
    put(0, 0, 0, 100, 60*256, 1000, -3*256, 5*256, 50, -20, 9'h111);
    put(1, 0, 9, 100, 70*256, 1150, 0, 30*256, 0, 0, 9'h022);
    model(10); run_line(10, 300);
    check_display("R5 depth gradient against flat span");
  endtask

  task automatic t_depth();
    clear_recs();
    put(0, 0, 49, 100, 20*256, 500, 0, 40*256, 0, 0, 9'd1);
    put(1, 0, 49, 100, 40*256, 300, 0, 40*256, 0, 0, 9'd2);
    put(2, 0, 49, 100, 70*256, 700, 0, 30*256, 0, 0, 9'd3);
    put(3, 0, 49, 100, 90*256, 700, 0, 5*256, 0, 0, 9'd4);
    model(50); run_line(50, 400);
    check_display("R6 strict depth test");
    pix_x = 8'd92; #1; chk("R6 equal depth keeps first", pix_color, 3);
    pix_x = 8'd50; #1; chk("R6 nearer wins", pix_color, 2);
  endtask

  task automatic t_clamp();
    clear_recs();
    put(0, 0, 0, 100, 10*256, 800, -2*256, 256, 4, 9, 9'd7);
    put(1, 0, 0, 100, 150*256, 100, 3*256, -3*256, 0, 0, 9'd8);
    put(2, 0, 0, 100, 250*256, 100, 2*256, 2*256, 0, 0, 9'd9);
    put(3, 0, 0, 100, 5*256, 100, -2*256, -2*256, 0, 0, 9'd10);
    model(10); run_line(10, 300);
    check_display("R7 clamp and skipped spans");
    pix_x = 8'd150; #1; chk("R7 inverted span skipped", pix_color, 0);
  endtask

  task automatic t_clear();
    clear_recs();
    put(0, 0, 0, 20, 100*256, 100, -256, 256, 0, 0, 9'd5);
    model(10); run_line(10, 300);
    check_display("R2 drawn line shown after swap");
    model(40); run_line(40, 300);
    check_display("R2 buffer emptied on reuse");
  endtask

  task automatic t_queue();
    clear_recs();
    for (int i = 0; i < 16; i++) put(i, 0, 29, 40, i*16*256, 100+i, 0, 9*256, 0, 0, i+1);
    model(30); run_line(30, 400);
    check_display("R10 sixteen spans through full queue");
  endtask

  task automatic t_timing();
    clear_recs();
    put(0, 0, 0, 200, 128*256, 100, -2*256, 2*256, 0, 0, 9'h155);
    model(100); run_line(100, 262);
    check_display("R8 full span in budget");
    chk("R8 no drop at 262 cycles", line_dropped, 0);
    run_line(100, 100);
    chk("R9 drop flag set", line_dropped, 1);
    pix_x = 8'd0; #1; chk("R9 partial start drawn", pix_color, 9'h155);
    pix_x = 8'd255; #1; chk("R9 unfinished end dropped", pix_color, 0);
    run_line(150, 300);
    chk("R9 flag clears next line", line_dropped, 0);
  endtask

  initial begin
    clear_recs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dir1();
    t_interp();
    t_depth();
    t_clamp();
    t_clear();
    t_queue();
    t_timing();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule